// File: doc/BRIEF.md
# Indexed Effective-Address Sequencer

This unit produces the bus address sequence that an 8-bit processor with a 16-bit address bus needs to resolve one operand address. It covers zero-page indexed, absolute indexed, zero-page pre-indexed indirect, taken relative branch, indirect jump, stack push and stack pull. Indexing is always done on the low byte first. The unit then reports the extra cycles that result: a dummy read at an address whose high byte has not yet been corrected, and reads of pointer bytes that wrap inside their page.

A controller pulses `start_i` together with a mode code and its operands. The unit then drives one bus access per clock on `bus_addr_o`. For read cycles it samples `rdata_i` at the clock edge that ends the cycle. When the final address is ready it raises `done_o` for one clock with that address on `ea_o`. Data arithmetic and memory stay outside the unit.

Top module: `ea_unit`

## Requirements
- R1: After reset, and whenever reset is asserted, the unit is idle: `busy_o`, `done_o`, `bus_rd_o`, `bus_wr_o` and `dummy_o` are low, `bus_addr_o` is 0 and `sp_o` is 0.
- R2: Mode 0 (index X) and mode 1 (index Y) are zero-page indexed. The unit does one dummy read at 0x00 concatenated with the operand low byte, then completes with `ea_o` = (operand low + index) mod 256 in page 0.
- R3: Mode 2 (index X) and mode 3 (index Y) are absolute indexed. For a read whose low-byte sum does not carry, the unit completes one clock after the start with `ea_o` = operand + index and makes no bus access.
- R4: In modes 2 and 3, when the low-byte sum carries, the unit does one dummy read at {operand high byte, low byte of the sum}, then completes with `ea_o` = operand + index, 16-bit wrapping.
- R5: In modes 2 and 3 with `rmw_i` high (write or read-modify-write), the dummy read at {operand high byte, low byte of the sum} is always made, even when no carry occurs.
- R6: Mode 4 is pre-indexed indirect. The unit does a dummy read at {0x00, operand low}. It then reads the pointer low byte at {0x00, (operand low + X) mod 256} and the pointer high byte at {0x00, (that pointer + 1) mod 256}. It completes with `ea_o` = {high, low}.
- R7: Mode 5 is a taken branch, with target = `pc_i` + sign-extended operand low byte. If the target's high byte differs from the high byte of `pc_i`, one dummy read is made at {`pc_i` high byte, target low byte}. Otherwise no bus access is made. It completes with `ea_o` = target.
- R8: Mode 6 is an indirect jump. The unit reads the target low byte at the operand address and the target high byte at {operand high byte, (operand low + 1) mod 256}. It completes with `ea_o` = {high, low}.
- R9: Mode 7 is a push: one write at 0x0100 | S, then `sp_o` = S - 1. Mode 8 is a pull: one read at 0x0100 | (S + 1) mod 256, then `sp_o` = S + 1. In both modes `ea_o` is the accessed address. For all other modes `sp_o` takes `sp_i` unchanged.
- R10: `done_o` is high for exactly one clock. `busy_o` is high from the clock after a start is accepted through the `done_o` clock. While `busy_o` is high, `start_i` is ignored.
- R11: Mode codes 9 to 15 complete one clock after the start with `ea_o` = operand and no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| mode_i | input | 4 | Addressing mode code |
| operand_i | input | 16 | Base address, zero-page operand, pointer or branch offset (low byte) |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| pc_i | input | 16 | Program counter following the branch |
| sp_i | input | 8 | Stack pointer |
| rmw_i | input | 1 | High for indexed write or read-modify-write |
| rdata_i | input | 8 | Read data for pointer fetches |
| bus_addr_o | output | 16 | Bus address of the current access |
| bus_rd_o | output | 1 | Current access is a read |
| bus_wr_o | output | 1 | Current access is a write |
| dummy_o | output | 1 | Current read is a discarded dummy read |
| ea_o | output | 16 | Final effective address, valid with done_o |
| sp_o | output | 8 | Updated stack pointer, valid with done_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench builds the unit with its default 16-bit address and 8-bit data widths. With these widths, every page boundary is only one index value away from a chosen base. The vectors therefore place bases at 0xF0, 0xFA, 0xFF and 0xFFFF to reach low-byte carries, zero-page pointer wrap, stack-pointer wrap through 0x00/0xFF and 16-bit wrap at the top of memory. The bench's memory model returns a byte that depends on both address bytes. A pointer fetch that leaves its page therefore shows up as a different final address.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam logic [3:0] MD_ZP_X    = 4'd0;
  localparam logic [3:0] MD_ZP_Y    = 4'd1;
  localparam logic [3:0] MD_ABS_X   = 4'd2;
  localparam logic [3:0] MD_ABS_Y   = 4'd3;
  localparam logic [3:0] MD_IND_X   = 4'd4;
  localparam logic [3:0] MD_REL     = 4'd5;
  localparam logic [3:0] MD_JMP_IND = 4'd6;
  localparam logic [3:0] MD_PUSH    = 4'd7;
  localparam logic [3:0] MD_PULL    = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DUMMY,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_STACK,
    ST_FIN
  } ea_state_e;
endpackage

// File: rtl/ea_index_adder.sv
// Adds an 8-bit offset to a full address; reports the low-byte-only partial result.
module ea_index_adder #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter bit SIGNED_OFS = 1'b0
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] ofs_i,
  output logic [AW-1:0] partial_o,
  output logic [AW-1:0] full_o,
  output logic          cross_o
);
  localparam int HW = AW - DW;

  logic [AW-1:0] ofs_ext;

  generate
    if (SIGNED_OFS) begin : g_sext
      assign ofs_ext = {{HW{ofs_i[DW-1]}}, ofs_i};
    end else begin : g_zext
      assign ofs_ext = {{HW{1'b0}}, ofs_i};
    end
  endgenerate

  assign full_o    = base_i + ofs_ext;
  assign partial_o = {base_i[AW-1:DW], full_o[DW-1:0]};
  assign cross_o   = (full_o[AW-1:DW] != base_i[AW-1:DW]);

  // R4: without a page change the uncorrected address is already final
  always_comb begin
    if (!cross_o) begin
      assert_partial_final_R4: assert (partial_o == full_o);
    end
  end
endmodule

// File: rtl/ea_page_adder.sv
// In-page add: carry out of the low byte is dropped.
module ea_page_adder #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-DW-1:0] page_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [AW-1:0]    addr_o
);
  logic [DW-1:0] sum;
  assign sum    = a_i + b_i;
  assign addr_o = {page_i, sum};
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int unsigned STACK_PAGE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] operand_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic          rmw_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          dummy_o,
  output logic [AW-1:0] ea_o,
  output logic [DW-1:0] sp_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int HW = AW - DW;
  localparam logic [HW-1:0] ZP_PAGE  = '0;
  localparam logic [HW-1:0] STK_PAGE = HW'(STACK_PAGE);

  ea_state_e     state_q;
  logic [3:0]    mode_q;
  logic [AW-1:0] a0_q, plo_q, phi_q, ea_q;
  logic [DW-1:0] lo_q, sp_q;
  logic          push_q;

  logic          accept;
  logic          use_y;
  logic [DW-1:0] idx;
  logic [AW-1:0] abs_partial, abs_full, rel_partial, rel_full;
  logic          abs_cross, rel_cross;
  logic [AW-1:0] zp_sum, inc_addr, stk_addr, zp_base;
  logic          is_jind, is_pull;
  logic [HW-1:0] inc_page;
  logic [DW-1:0] inc_a;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign use_y   = (mode_i == MD_ZP_Y) || (mode_i == MD_ABS_Y);
  assign idx     = use_y ? y_i : x_i;
  assign is_jind = (mode_i == MD_JMP_IND);
  assign is_pull = (mode_i == MD_PULL);
  assign zp_base = {ZP_PAGE, operand_i[DW-1:0]};

  ea_index_adder #(.AW(AW), .DW(DW), .SIGNED_OFS(1'b0)) u_abs_add (
    .base_i   (operand_i),
    .ofs_i    (idx),
    .partial_o(abs_partial),
    .full_o   (abs_full),
    .cross_o  (abs_cross)
  );

  ea_index_adder #(.AW(AW), .DW(DW), .SIGNED_OFS(1'b1)) u_rel_add (
    .base_i   (pc_i),
    .ofs_i    (operand_i[DW-1:0]),
    .partial_o(rel_partial),
    .full_o   (rel_full),
    .cross_o  (rel_cross)
  );

  ea_page_adder #(.AW(AW), .DW(DW)) u_zp_add (
    .page_i(ZP_PAGE),
    .a_i   (operand_i[DW-1:0]),
    .b_i   (idx),
    .addr_o(zp_sum)
  );

  // second pointer byte: zero page for indirect-X, operand page for indirect jump
  assign inc_page = is_jind ? operand_i[AW-1:DW] : ZP_PAGE;
  assign inc_a    = is_jind ? operand_i[DW-1:0] : zp_sum[DW-1:0];

  ea_page_adder #(.AW(AW), .DW(DW)) u_inc_add (
    .page_i(inc_page),
    .a_i   (inc_a),
    .b_i   (DW'(1)),
    .addr_o(inc_addr)
  );

  ea_page_adder #(.AW(AW), .DW(DW)) u_stk_add (
    .page_i(STK_PAGE),
    .a_i   (sp_i),
    .b_i   (DW'(is_pull)),
    .addr_o(stk_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      a0_q    <= '0;
      plo_q   <= '0;
      phi_q   <= '0;
      ea_q    <= '0;
      lo_q    <= '0;
      sp_q    <= '0;
      push_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q <= mode_i;
            sp_q   <= sp_i;
            push_q <= 1'b0;
            unique case (mode_i)
              MD_ZP_X, MD_ZP_Y: begin
                a0_q    <= zp_base;
                ea_q    <= zp_sum;
                state_q <= ST_DUMMY;
              end
              MD_ABS_X, MD_ABS_Y: begin
                a0_q    <= abs_partial;
                ea_q    <= abs_full;
                state_q <= (abs_cross || rmw_i) ? ST_DUMMY : ST_FIN;
              end
              MD_IND_X: begin
                a0_q    <= zp_base;
                plo_q   <= zp_sum;
                phi_q   <= inc_addr;
                state_q <= ST_DUMMY;
              end
              MD_REL: begin
                a0_q    <= rel_partial;
                ea_q    <= rel_full;
                state_q <= rel_cross ? ST_DUMMY : ST_FIN;
              end
              MD_JMP_IND: begin
                plo_q   <= operand_i;
                phi_q   <= inc_addr;
                state_q <= ST_PTR_LO;
              end
              MD_PUSH: begin
                a0_q    <= stk_addr;
                ea_q    <= stk_addr;
                sp_q    <= sp_i - DW'(1);
                push_q  <= 1'b1;
                state_q <= ST_STACK;
              end
              MD_PULL: begin
                a0_q    <= stk_addr;
                ea_q    <= stk_addr;
                sp_q    <= sp_i + DW'(1);
                state_q <= ST_STACK;
              end
              default: begin
                ea_q    <= operand_i;
                state_q <= ST_FIN;
              end
            endcase
          end
        end
        ST_DUMMY:  state_q <= (mode_q == MD_IND_X) ? ST_PTR_LO : ST_FIN;
        ST_PTR_LO: begin
          lo_q    <= rdata_i;
          state_q <= ST_PTR_HI;
        end
        ST_PTR_HI: begin
          ea_q    <= AW'({rdata_i, lo_q});
          state_q <= ST_FIN;
        end
        ST_STACK:  state_q <= ST_FIN;
        ST_FIN:    state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_DUMMY, ST_STACK: bus_addr_o = a0_q;
      ST_PTR_LO:          bus_addr_o = plo_q;
      ST_PTR_HI:          bus_addr_o = phi_q;
      default:            bus_addr_o = '0;
    endcase
  end

  assign bus_rd_o = (state_q == ST_DUMMY) || (state_q == ST_PTR_LO) ||
                    (state_q == ST_PTR_HI) || ((state_q == ST_STACK) && !push_q);
  assign bus_wr_o = (state_q == ST_STACK) && push_q;
  assign dummy_o  = (state_q == ST_DUMMY);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign ea_o     = ea_q;
  assign sp_o     = sp_q;

  logic zp_mode_q, idx_mode_q, stk_mode_q;
  assign zp_mode_q  = (mode_q == MD_ZP_X) || (mode_q == MD_ZP_Y) || (mode_q == MD_IND_X);
  assign idx_mode_q = (mode_q == MD_ABS_X) || (mode_q == MD_ABS_Y) || (mode_q == MD_REL);
  assign stk_mode_q = (mode_q == MD_PUSH) || (mode_q == MD_PULL);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mode_q));

  assert_rd_wr_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  assert_zp_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && zp_mode_q) |-> (bus_addr_o[AW-1:DW] == ZP_PAGE));

  assert_dummy_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dummy_o && idx_mode_q) |-> (bus_addr_o[DW-1:0] == ea_q[DW-1:0]));

  assert_stack_page_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_o || bus_wr_o) && stk_mode_q) |-> (bus_addr_o[AW-1:DW] == STK_PAGE));

  assert_dummy_is_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_o |-> (bus_rd_o && !bus_wr_o));
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] op;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        rmw;
    logic [1:0]  nbus;
    logic [15:0] a0;
    logic [15:0] a1;
    logic [15:0] a2;
    logic [1:0]  ndum;
    logic        nwr;
    logic [15:0] ea;
    logic [7:0]  spx;
  } vec_t;

  localparam int NV = 22;
  // mode op x y pc sp rmw | nbus a0 a1 a2 ndum nwr ea spx
  localparam vec_t VECS [NV] = '{
    '{4'd0, 16'h0080, 8'h10, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd1, 16'h0080, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h0090, 8'h40},
    '{4'd0, 16'h00F0, 8'h20, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd1, 16'h00F0, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h0010, 8'h40},
    '{4'd1, 16'h0005, 8'h01, 8'hFF, 16'h0000, 8'h40, 1'b0, 2'd1, 16'h0005, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h0004, 8'h40},
    '{4'd2, 16'h1200, 8'h34, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h1234, 8'h40},
    '{4'd2, 16'h12F0, 8'h20, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd1, 16'h1210, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h1310, 8'h40},
    '{4'd3, 16'hFFFF, 8'h00, 8'h01, 16'h0000, 8'h40, 1'b0, 2'd1, 16'hFF00, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h0000, 8'h40},
    '{4'd2, 16'h2000, 8'h05, 8'h00, 16'h0000, 8'h40, 1'b1, 2'd1, 16'h2005, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h2005, 8'h40},
    '{4'd3, 16'h20FF, 8'h00, 8'h02, 16'h0000, 8'h40, 1'b1, 2'd1, 16'h2001, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h2101, 8'h40},
    '{4'd4, 16'h0020, 8'h05, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd3, 16'h0020, 16'h0025, 16'h0026, 2'd1, 1'b0, 16'h3736, 8'h40},
    '{4'd4, 16'h00FA, 8'h05, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd3, 16'h00FA, 16'h00FF, 16'h0000, 2'd1, 1'b0, 16'h1110, 8'h40},
    '{4'd4, 16'h00F0, 8'h20, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd3, 16'h00F0, 16'h0010, 16'h0011, 2'd1, 1'b0, 16'h2221, 8'h40},
    '{4'd5, 16'h0010, 8'h00, 8'h00, 16'h1000, 8'h40, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h1010, 8'h40},
    '{4'd5, 16'h00F0, 8'h00, 8'h00, 16'h1005, 8'h40, 1'b0, 2'd1, 16'h10F5, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h0FF5, 8'h40},
    '{4'd5, 16'h0020, 8'h00, 8'h00, 16'h10F0, 8'h40, 1'b0, 2'd1, 16'h1010, 16'h0000, 16'h0000, 2'd1, 1'b0, 16'h1110, 8'h40},
    '{4'd5, 16'hAB7F, 8'h00, 8'h00, 16'h2000, 8'h40, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h207F, 8'h40},
    '{4'd6, 16'h1234, 8'h00, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd2, 16'h1234, 16'h1235, 16'h0000, 2'd0, 1'b0, 16'h5857, 8'h40},
    '{4'd6, 16'h30FF, 8'h00, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd2, 16'h30FF, 16'h3000, 16'h0000, 2'd0, 1'b0, 16'h4140, 8'h40},
    '{4'd7, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'hFD, 1'b0, 2'd1, 16'h01FD, 16'h0000, 16'h0000, 2'd0, 1'b1, 16'h01FD, 8'hFC},
    '{4'd8, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'hFC, 1'b0, 2'd1, 16'h01FD, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h01FD, 8'hFD},
    '{4'd7, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 1'b0, 2'd1, 16'h0100, 16'h0000, 16'h0000, 2'd0, 1'b1, 16'h0100, 8'hFF},
    '{4'd8, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'hFF, 1'b0, 2'd1, 16'h0100, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h0100, 8'h00},
    '{4'd9, 16'hBEEF, 8'h00, 8'h00, 16'h0000, 8'h40, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'hBEEF, 8'h40}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] operand = '0;
  logic [7:0]  xr = '0, yr = '0, spr = '0;
  logic [15:0] pc = '0;
  logic        rmw = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] bus_addr, ea;
  logic        bus_rd, bus_wr, dummy, busy, done;
  logic [7:0]  sp_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // memory model: byte depends on both address bytes
  assign rdata = bus_addr[7:0] + bus_addr[15:8] + 8'h11;

  ea_unit u_ea_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .operand_i(operand), .x_i(xr), .y_i(yr), .pc_i(pc), .sp_i(spr),
    .rmw_i(rmw), .rdata_i(rdata), .bus_addr_o(bus_addr), .bus_rd_o(bus_rd),
    .bus_wr_o(bus_wr), .dummy_o(dummy), .ea_o(ea), .sp_o(sp_out),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    case (v.mode)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return v.rmw ? "R5" : ((v.nbus != 0) ? "R4" : "R3");
      4'd4:       return "R6";
      4'd5:       return "R7";
      4'd6:       return "R8";
      4'd7, 4'd8: return "R9";
      default:    return "R11";
    endcase
  endfunction

  logic [15:0] seen_addr [3];
  int nb, nd, nw;
  logic got_done;

  // call at a negedge while idle; returns at the negedge of the done cycle
  task automatic run_seq(input vec_t v, input logic hold_start);
    mode = v.mode; operand = v.op; xr = v.x; yr = v.y; pc = v.pc;
    spr = v.sp; rmw = v.rmw; start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    else begin mode = 4'd9; operand = 16'hBEEF; end
    nb = 0; nd = 0; nw = 0; got_done = 1'b0;
    for (int c = 0; c < 8 && !got_done; c++) begin
      if (done) got_done = 1'b1;
      else begin
        if ((bus_rd || bus_wr) && nb < 3) begin seen_addr[nb] = bus_addr; nb++; end
        if (dummy) nd++;
        if (bus_wr) nw++;
        @(negedge clk);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog act=%h exp=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1", "idle flags", {busy, done}, 0);
    chk(!bus_rd && !bus_wr && !dummy, "R1", "no access", {bus_rd, bus_wr, dummy}, 0);
    chk(bus_addr == 16'h0 && sp_out == 8'h0, "R1", "addr/sp", {bus_addr, sp_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = tag_of(v);
      run_seq(v, 1'b0);
      chk(got_done, t, "done seen", got_done, 1);
      chk(nb == v.nbus, t, "bus count", nb, v.nbus);
      if (nb > 0 && v.nbus > 0) chk(seen_addr[0] == v.a0, t, "addr0", seen_addr[0], v.a0);
      if (nb > 1 && v.nbus > 1) chk(seen_addr[1] == v.a1, t, "addr1", seen_addr[1], v.a1);
      if (nb > 2 && v.nbus > 2) chk(seen_addr[2] == v.a2, t, "addr2", seen_addr[2], v.a2);
      chk(nd == v.ndum, t, "dummy count", nd, v.ndum);
      chk(nw == v.nwr, t, "write count", nw, v.nwr);
      chk(ea == v.ea, t, "ea", ea, v.ea);
      chk(sp_out == v.spx, t, "sp", sp_out, v.spx);
      @(negedge clk);
      chk(!done && !busy, "R10", "done one clock", {done, busy}, 0);
    end

    // R10: start held high with another mode during a sequence is ignored
    run_seq(VECS[8], 1'b1);
    chk(nb == 3, "R10", "ignored start bus count", nb, 3);
    chk(ea == 16'h3736, "R10", "ignored start ea", ea, 16'h3736);
    @(negedge clk);
    chk(!busy, "R10", "idle after done", busy, 0);

    // R10: busy through the sequence
    mode = 4'd4; operand = 16'h0020; xr = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R10", "busy in sequence", {busy, done}, 2'b10);
    // R1: reset mid-sequence returns to idle at once
    rst_n = 1'b0;
    #1;
    chk(!busy && !bus_rd && bus_addr == 16'h0, "R1", "async reset", {busy, bus_rd, bus_addr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule